// File: doc/BRIEF.md
# Dual-Style Host Bus Adapter

This block connects an 8-bit host processor to a display controller's register file. The host side can use one of two bus styles, and static mode pins choose which one. In the strobe-pair style, one pin is an active-low read strobe and the other is an active-low write strobe. In the enable-clock style, the first pin is an enable clock and the second pin is a read/write direction level. A chip-select input gates every access. A register-select bit (`a0`) marks each access as command or data.

All host pins are asynchronous to the internal clock. They pass through a synchronizer before the access is decoded. A write is taken when its access ends. It produces exactly one single-cycle internal write pulse, and the byte is placed in the command holding register or the parameter holding register. A read drives a status byte or the next data byte onto the split data bus. The output enable of that bus is high only while the read lasts. When a data read ends, the block pulses one cycle so that the data source behind it can advance.

Top module: `hostbus_adapter`

## Requirements
- R1: A synchronous reset clears `cmd_q`, `prm_q`, `bus_oe`, `wr_pulse` and `rd_pulse` to 0.
- R2: `mode_sel` = 2'b00 selects the strobe-pair style. Each of the other three values selects the enable-clock style. Every completed access gives exactly one internal pulse.
- R3: In strobe-pair style, a write is `cs_n` low and `strb_b` low. On the third rising clock edge after `strb_b` is released, `wr_pulse` is high for exactly one cycle and `wr_byte` holds the byte that was on `bus_di`.
- R4: A write with `a0`=1 loads `cmd_q` and sets `wr_cmd`=1. A write with `a0`=0 loads `prm_q` and sets `wr_cmd`=0. The other holding register keeps its value.
- R5: In enable-clock style, a write is `cs_n` low, `strb_a` (enable) high and `strb_b` (direction) low. The write completes when the enable falls.
- R6: While `cs_n` is high, strobe activity causes no pulse, leaves both holding registers unchanged and keeps `bus_oe` low.
- R7: A read with `a0`=0 drives the status byte {`busy`, `stat_lo`}, with the busy flag in bit 7. A read with `a0`=1 drives `rd_data`.
- R8: `bus_oe` is high only during a read. It rises on the third rising edge after the read begins and falls on the third rising edge after the read ends.
- R9: `rd_pulse` is high for one cycle after each data read (`a0`=1). A status read (`a0`=0) produces no `rd_pulse`.
- R10: In enable-clock style, no access takes place while the enable is low, whatever the level on the direction pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Bus style select (00 strobe-pair, else enable-clock) |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Register select: 1 command/data, 0 parameter/status |
| strb_a | input | 1 | Read strobe (active low) or enable clock |
| strb_b | input | 1 | Write strobe (active low) or read/write level (1 = read) |
| bus_di | input | 8 | Host data into the block |
| bus_do | output | 8 | Read data toward the host pad |
| bus_oe | output | 1 | Pad drive enable for `bus_do` |
| busy | input | 1 | Busy flag reported in status bit 7 |
| stat_lo | input | 7 | Lower status bits |
| rd_data | input | 8 | Next data byte from the controller |
| wr_pulse | output | 1 | One-cycle pulse per completed write |
| wr_cmd | output | 1 | Last write was a command (`a0`=1) |
| wr_byte | output | 8 | Byte of the last completed write |
| cmd_q | output | 8 | Command holding register |
| prm_q | output | 8 | Parameter holding register |
| rd_pulse | output | 1 | One-cycle pulse after each data read |

## Verification
A table-driven pass runs writes and reads with both `a0` values. It covers the strobe-pair style and all three enable-clock codes, so a fault in mode decoding or in command/parameter steering shows up as the wrong register changing or a missing pulse. Pulse counts are compared per access, which separates a missing pulse from a repeated one, and status reads are checked to produce no data-read pulse. Directed cases measure the exact edges at which `wr_pulse` and `bus_oe` change. They also try strobes with chip select high, an enable-clock direction level with the enable low, a cleared busy flag, and a reset in the middle of a run.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    STYLE_STROBE = 1'b0,
    STYLE_ENABLE = 1'b1
  } bus_style_e;

  // Only the all-zero code picks separate read/write strobes.
  function automatic bus_style_e style_of(input logic [1:0] m);
    return (m == 2'b00) ? STYLE_STROBE : STYLE_ENABLE;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 12,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= INIT;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= INIT;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic [1:0] mode_sel,
  input  logic       cs_n,
  input  logic       strb_a,
  input  logic       strb_b,
  output logic       rd_act,
  output logic       wr_act
);
  bus_style_e style;
  assign style = style_of(mode_sel);

  always_comb begin
    if (style == STYLE_STROBE) begin
      // Write strobe wins if both strobes are low.
      wr_act = !cs_n && !strb_b;
      rd_act = !cs_n && !strb_a && strb_b;
    end else begin
      // strb_a is the enable, strb_b the direction (1 = read).
      wr_act = !cs_n && strb_a && !strb_b;
      rd_act = !cs_n && strb_a && strb_b;
    end
  end
endmodule

// File: rtl/hostbus_adapter.sv
module hostbus_adapter #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic [DW-1:0] bus_di,
  output logic [DW-1:0] bus_do,
  output logic          bus_oe,
  input  logic          busy,
  input  logic [DW-2:0] stat_lo,
  input  logic [DW-1:0] rd_data,
  output logic          wr_pulse,
  output logic          wr_cmd,
  output logic [DW-1:0] wr_byte,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] prm_q,
  output logic          rd_pulse
);
  localparam int SW = DW + 4;
  localparam logic [SW-1:0] IDLE = {{DW{1'b0}}, 1'b0, 1'b1, 1'b1, 1'b1};

  logic [SW-1:0] raw, syn;
  logic [DW-1:0] s_dat, hold_dat;
  logic          s_a0, s_cs_n, s_a, s_b;
  logic          rd_act, wr_act, rd_q, wr_q, hold_a0;
  logic          wr_end, rd_end;

  assign raw = {bus_di, a0, cs_n, strb_a, strb_b};

  hb_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT(IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  assign s_dat  = syn[SW-1:4];
  assign s_a0   = syn[3];
  assign s_cs_n = syn[2];
  assign s_a    = syn[1];
  assign s_b    = syn[0];

  hb_decode u_dec (
    .mode_sel (mode_sel),
    .cs_n     (s_cs_n),
    .strb_a   (s_a),
    .strb_b   (s_b),
    .rd_act   (rd_act),
    .wr_act   (wr_act)
  );

  assign wr_end = wr_q && !wr_act;
  assign rd_end = rd_q && !rd_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      hold_dat <= '0;
      hold_a0  <= 1'b0;
      wr_pulse <= 1'b0;
      wr_cmd   <= 1'b0;
      wr_byte  <= '0;
      cmd_q    <= '0;
      prm_q    <= '0;
      rd_pulse <= 1'b0;
      bus_oe   <= 1'b0;
      bus_do   <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      // Keep the last values seen while the access was active.
      if (wr_act) begin
        hold_dat <= s_dat;
        hold_a0  <= s_a0;
      end else if (rd_act) begin
        hold_a0  <= s_a0;
      end
      wr_pulse <= wr_end;
      if (wr_end) begin
        wr_byte <= hold_dat;
        wr_cmd  <= hold_a0;
        if (hold_a0) cmd_q <= hold_dat;
        else         prm_q <= hold_dat;
      end
      rd_pulse <= rd_end && hold_a0;
      bus_oe   <= rd_act;
      if (!rd_act)   bus_do <= '0;
      else if (s_a0) bus_do <= rd_data;
      else           bus_do <= {busy, stat_lo};
    end
  end

  // R2: the decoder never reports a read and a write together
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_act, wr_act}));

  // R3: an internal write pulse lasts a single cycle
  p_wr_single_r3: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);

  // R9: a data-read pulse lasts a single cycle
  p_rd_single_r9: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> !rd_pulse);

  // R4: the command register changes only with a command write pulse
  p_cmd_steer_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_q) |-> (wr_pulse && wr_cmd));

  // R4: the parameter register changes only with a parameter write pulse
  p_prm_steer_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(prm_q) |-> (wr_pulse && !wr_cmd));
endmodule

// File: tb/sim_hostbus_adapter.sv
module sim_hostbus_adapter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       cs_n = 1'b1, a0 = 1'b0, strb_a = 1'b1, strb_b = 1'b1;
  logic [7:0] bus_di = 8'h00, rd_data = 8'h3C;
  logic       busy = 1'b1;
  logic [6:0] stat_lo = 7'h25;
  logic [7:0] bus_do, wr_byte, cmd_q, prm_q;
  logic       bus_oe, wr_pulse, wr_cmd, rd_pulse;

  int n_cmp = 0, n_bad = 0, n_wr = 0, n_rd = 0;
  logic [7:0] m_cmd = 8'h00, m_prm = 8'h00;

  hostbus_adapter u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .a0(a0),
    .strb_a(strb_a), .strb_b(strb_b), .bus_di(bus_di), .bus_do(bus_do),
    .bus_oe(bus_oe), .busy(busy), .stat_lo(stat_lo), .rd_data(rd_data),
    .wr_pulse(wr_pulse), .wr_cmd(wr_cmd), .wr_byte(wr_byte),
    .cmd_q(cmd_q), .prm_q(prm_q), .rd_pulse(rd_pulse)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && wr_pulse) n_wr++;
    if (!rst && rd_pulse) n_rd++;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go_idle(input logic [1:0] m);
    @(negedge clk);
    cs_n = 1'b1;
    mode_sel = m;
    if (m == 2'b00) begin strb_a = 1'b1; strb_b = 1'b1; end
    else begin strb_a = 1'b0; strb_b = 1'b1; end
    repeat (4) @(negedge clk);
  endtask

  task automatic access(input logic [1:0] m, input logic rd, input logic sel,
                        input logic [7:0] dat, output logic [7:0] got_do,
                        output logic got_oe);
    go_idle(m);
    cs_n = 1'b0; a0 = sel; bus_di = dat;
    if (m == 2'b00) begin
      if (rd) strb_a = 1'b0; else strb_b = 1'b0;
    end else begin
      strb_b = rd;
      @(negedge clk);
      strb_a = 1'b1;
    end
    repeat (6) @(negedge clk);
    got_do = bus_do; got_oe = bus_oe;
    if (m == 2'b00) begin strb_a = 1'b1; strb_b = 1'b1; end
    else strb_a = 1'b0;
    repeat (6) @(negedge clk);
    cs_n = 1'b1; bus_di = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  // {mode[1:0], read, a0, write byte, expected}
  localparam logic [19:0] VEC [10] = '{
    {2'b00, 1'b0, 1'b1, 8'h4C, 8'h4C},
    {2'b00, 1'b0, 1'b0, 8'h12, 8'h12},
    {2'b00, 1'b1, 1'b0, 8'h00, 8'hA5},
    {2'b00, 1'b1, 1'b1, 8'h00, 8'h3C},
    {2'b01, 1'b0, 1'b1, 8'h81, 8'h81},
    {2'b01, 1'b0, 1'b0, 8'hE7, 8'hE7},
    {2'b01, 1'b1, 1'b0, 8'h00, 8'hA5},
    {2'b10, 1'b1, 1'b1, 8'h00, 8'h3C},
    {2'b11, 1'b0, 1'b1, 8'h07, 8'h07},
    {2'b10, 1'b0, 1'b0, 8'h99, 8'h99}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] gd;
    logic go;
    int pw, pr;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_q", cmd_q, 8'h00);
    chk("R1 prm_q", prm_q, 8'h00);
    chk("R1 oe/pulses", {5'b0, bus_oe, wr_pulse, rd_pulse}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      logic [1:0] m; logic rd, sel; logic [7:0] dat, exp;
      {m, rd, sel, dat, exp} = VEC[i];
      pw = n_wr; pr = n_rd;
      access(m, rd, sel, dat, gd, go);
      if (!rd) begin
        if (sel) m_cmd = dat; else m_prm = dat;
        chk((m == 2'b00) ? "R3 wr_byte" : "R5 wr_byte", wr_byte, exp);
        chk("R4 cmd_q", cmd_q, m_cmd);
        chk("R4 prm_q", prm_q, m_prm);
        chk("R4 wr_cmd", {7'b0, wr_cmd}, {7'b0, sel});
        chk("R2 write pulse count", 8'(n_wr - pw), 8'd1);
      end else begin
        chk("R8 oe during read", {7'b0, go}, 8'h01);
        chk("R7 read byte", gd, exp);
        chk("R9 read pulse count", 8'(n_rd - pr), {7'b0, sel});
        chk("R2 no write on read", 8'(n_wr - pw), 8'd0);
      end
    end

    // R3 exact write-pulse edges
    go_idle(2'b00);
    cs_n = 1'b0; a0 = 1'b0; bus_di = 8'h5A; strb_b = 1'b0;
    repeat (5) @(negedge clk);
    strb_b = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R3 no pulse at edge 2", {7'b0, wr_pulse}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R3 pulse at edge 3", {7'b0, wr_pulse}, 8'h01);
    chk("R3 prm_q value", prm_q, 8'h5A);
    @(posedge clk); @(negedge clk);
    chk("R3 pulse one cycle", {7'b0, wr_pulse}, 8'h00);
    m_prm = 8'h5A;

    // R8 exact output-enable edges
    go_idle(2'b00);
    cs_n = 1'b0; a0 = 1'b1; strb_a = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8 oe low at edge 2", {7'b0, bus_oe}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R8 oe high at edge 3", {7'b0, bus_oe}, 8'h01);
    repeat (3) @(negedge clk);
    strb_a = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8 oe held at edge 2", {7'b0, bus_oe}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R8 oe off at edge 3", {7'b0, bus_oe}, 8'h00);

    // R6 strobes with chip select high
    go_idle(2'b00);
    pw = n_wr; pr = n_rd;
    a0 = 1'b1; bus_di = 8'hFF; strb_b = 1'b0;
    repeat (6) @(negedge clk);
    strb_b = 1'b1;
    repeat (6) @(negedge clk);
    strb_a = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 oe stays low", {7'b0, bus_oe}, 8'h00);
    strb_a = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 cmd_q unchanged", cmd_q, m_cmd);
    chk("R6 no pulses", 8'((n_wr - pw) + (n_rd - pr)), 8'd0);

    // R10 enable low in enable-clock style
    go_idle(2'b01);
    pw = n_wr; pr = n_rd;
    cs_n = 1'b0; a0 = 1'b1; bus_di = 8'hC3; strb_b = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 oe low with enable low", {7'b0, bus_oe}, 8'h00);
    strb_b = 1'b0;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 no pulses", 8'((n_wr - pw) + (n_rd - pr)), 8'd0);
    chk("R10 cmd_q unchanged", cmd_q, m_cmd);

    // R7 busy flag cleared
    busy = 1'b0;
    access(2'b00, 1'b1, 1'b0, 8'h00, gd, go);
    chk("R7 status with busy clear", gd, 8'h25);

    // R1 reset in mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd_q after reset", cmd_q, 8'h00);
    chk("R1 prm_q after reset", prm_q, 8'h00);

    finish_run();
  end
endmodule